// File: doc/BRIEF.md
# Palette-Indexed Raster Pixel Fetch

This block turns raster timing into 24-bit pixel colour for a 640x480 display. A timing generator supplies, once per pixel clock, the horizontal and vertical sync levels and an active-video flag. The block counts a linear pixel address. That address reads an 8-bit palette index from an image store, and the index then selects a 24-bit colour word from a 256-entry palette.

The image store is read on the falling clock edge and the palette on the rising edge, so the two reads together take one pixel period. The colour word is split into three channels, each widened to 10 bits, and forced to black outside active video. The sync and active-video levels are delayed by the same two cycles so that they stay aligned with the colour.

The two stores hold fixed test contents. The palette is loaded during reset, and the image store is computed from the address, so a full 307200-word frame costs no storage. Both contents are defined below so that any pixel can be predicted.

Top module: `palette_raster_fetch`

## Requirements
- R1: While reset (active low) is asserted, all colour outputs are 0, the delayed active-video output is 0, both delayed sync outputs are 1, and the pixel address is 0.
- R2: When the horizontal and vertical sync inputs are both low in the same cycle, the 19-bit pixel address is 0 in the next cycle, even if active video is high in that cycle.
- R3: Otherwise the pixel address increases by one after each cycle in which active video is high, and holds its value after each cycle in which it is low.
- R4: The image store returns, for an address a below the frame depth (307200 by default), the index (a[7:0] + a[15:8]) mod 256, and returns index 0 for any address at or above the frame depth.
- R5: Palette entry i holds blue = i in bits 23:16, green = i XOR 0x5A in bits 15:8, and red = 255 - i in bits 7:0.
- R6: Each 8-bit channel value c is presented as the 10-bit value {c, c[7:6]}.
- R7: The colour for the pixel address held in cycle t, together with the sync and active-video inputs of cycle t, appears on the outputs in cycle t+2.
- R8: All three colour outputs are 0 in every cycle where the delayed active-video output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hsIn | input | 1 | Horizontal sync level from the timing generator |
| vsIn | input | 1 | Vertical sync level from the timing generator |
| blankNIn | input | 1 | Active-video flag, high while a pixel is shown |
| hsOut | output | 1 | Horizontal sync delayed to match the colour |
| vsOut | output | 1 | Vertical sync delayed to match the colour |
| blankNOut | output | 1 | Active-video flag delayed to match the colour |
| blueOut | output | 10 | Blue channel, widened |
| greenOut | output | 10 | Green channel, widened |
| redOut | output | 10 | Red channel, widened |

## Verification
The address clear and the address step can fall in the same cycle: both syncs low while active video is high. The bench drives exactly that case and expects the clear to win, so the next pixel comes from address 0 rather than from the incremented address. Long pseudo-random runs of the three timing inputs also produce sync-low-alone cycles, which must not clear. A frame depth shortened in the bench lets the sweep run past the end of the image store, and every cycle is compared against a two-stage reference model.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;

  typedef struct packed {
    logic clearAddr;
    logic stepAddr;
  } addrStrobe_t;

endpackage

// File: rtl/pfetch_ctrl.sv
module pfetch_ctrl
  import pfetch_pkg::*;
#(
  parameter int LAG = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hsIn,
  input  logic        vsIn,
  input  logic        blankNIn,
  output addrStrobe_t strobe,
  output logic        maskBlankN,
  output logic        hsOut,
  output logic        vsOut,
  output logic        blankNOut
);

  logic [LAG-1:0] hsLine;
  logic [LAG-1:0] vsLine;
  logic [LAG-1:0] bnLine;

  always_comb begin
    strobe.clearAddr = !hsIn && !vsIn;
    strobe.stepAddr  = blankNIn && !strobe.clearAddr;
  end

  generate
    for (genvar s = 0; s < LAG; s++) begin : g_tap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          hsLine[s] <= 1'b1;
          vsLine[s] <= 1'b1;
          bnLine[s] <= 1'b0;
        end else if (s == 0) begin
          hsLine[s] <= hsIn;
          vsLine[s] <= vsIn;
          bnLine[s] <= blankNIn;
        end else begin
          hsLine[s] <= hsLine[(s == 0) ? 0 : s-1];
          vsLine[s] <= vsLine[(s == 0) ? 0 : s-1];
          bnLine[s] <= bnLine[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign maskBlankN = bnLine[LAG-2];
  assign hsOut      = hsLine[LAG-1];
  assign vsOut      = vsLine[LAG-1];
  assign blankNOut  = bnLine[LAG-1];

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2'd2) |-> (hsOut == $past(hsIn, 2) && vsOut == $past(vsIn, 2)
                        && blankNOut == $past(blankNIn, 2))); // R7

endmodule

// File: rtl/pfetch_datapath.sv
module pfetch_datapath
  import pfetch_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int FRAME_WORDS = 307200,
  parameter int IDX_W       = 8,
  parameter int CH_W        = 8,
  parameter int OUT_W       = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  addrStrobe_t      strobe,
  input  logic             maskBlankN,
  output logic [OUT_W-1:0] blueOut,
  output logic [OUT_W-1:0] greenOut,
  output logic [OUT_W-1:0] redOut
);

  localparam int PAL_DEPTH = 1 << IDX_W;
  localparam int WORD_W    = 3 * CH_W;
  localparam int EXT_W     = OUT_W - CH_W;

  logic [ADDR_W-1:0] pixAddr;
  logic [IDX_W-1:0]  idxQ;
  logic [WORD_W-1:0] palMem [PAL_DEPTH];
  logic [WORD_W-1:0] palQ;

  // pixel address counter: clear beats step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pixAddr <= '0;
    else if (strobe.clearAddr) pixAddr <= '0;
    else if (strobe.stepAddr)  pixAddr <= pixAddr + 1'b1;
  end

  // image store: contents computed from the address, read on falling edge
  function automatic logic [IDX_W-1:0] imgWord(input logic [ADDR_W-1:0] a);
    if (a >= ADDR_W'(FRAME_WORDS)) return '0;
    return a[IDX_W-1:0] + a[2*IDX_W-1:IDX_W];
  endfunction

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) idxQ <= '0;
    else       idxQ <= imgWord(pixAddr);
  end

  // palette: loaded during reset, read on rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PAL_DEPTH; i++) begin
        palMem[i] <= {CH_W'(i), CH_W'(i) ^ CH_W'(8'h5A), CH_W'(PAL_DEPTH - 1 - i)};
      end
      palQ <= '0;
    end else begin
      palQ <= palMem[idxQ];
    end
  end

  // channel split, widening and blanking
  logic [CH_W-1:0]  chan [3];
  logic [OUT_W-1:0] wide [3];
  assign chan[0] = palQ[3*CH_W-1:2*CH_W];
  assign chan[1] = palQ[2*CH_W-1:CH_W];
  assign chan[2] = palQ[CH_W-1:0];

  generate
    for (genvar c = 0; c < 3; c++) begin : g_widen
      if (EXT_W > 0) begin : g_ext
        assign wide[c] = {chan[c], chan[c][CH_W-1 -: EXT_W]};
      end else begin : g_same
        assign wide[c] = chan[c][CH_W-1 -: OUT_W];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blueOut  <= '0;
      greenOut <= '0;
      redOut   <= '0;
    end else if (!maskBlankN) begin
      blueOut  <= '0;
      greenOut <= '0;
      redOut   <= '0;
    end else begin
      blueOut  <= wide[0];
      greenOut <= wide[1];
      redOut   <= wide[2];
    end
  end

  AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAddr |=> (pixAddr == '0)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepAddr && !strobe.clearAddr) |=> (pixAddr == $past(pixAddr) + 1'b1)); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.stepAddr && !strobe.clearAddr) |=> $stable(pixAddr)); // R3
  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !maskBlankN |=> (blueOut == '0 && greenOut == '0 && redOut == '0)); // R8

endmodule

// File: rtl/palette_raster_fetch.sv
module palette_raster_fetch
  import pfetch_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int FRAME_WORDS = 307200,
  parameter int IDX_W       = 8,
  parameter int CH_W        = 8,
  parameter int OUT_W       = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsIn,
  input  logic             vsIn,
  input  logic             blankNIn,
  output logic             hsOut,
  output logic             vsOut,
  output logic             blankNOut,
  output logic [OUT_W-1:0] blueOut,
  output logic [OUT_W-1:0] greenOut,
  output logic [OUT_W-1:0] redOut
);

  localparam int LAG = 2;

  addrStrobe_t strobe;
  logic        maskBlankN;

  pfetch_ctrl #(.LAG(LAG)) u_ctrl (
    .clk(clk), .rstN(rstN), .hsIn(hsIn), .vsIn(vsIn), .blankNIn(blankNIn),
    .strobe(strobe), .maskBlankN(maskBlankN),
    .hsOut(hsOut), .vsOut(vsOut), .blankNOut(blankNOut)
  );

  pfetch_datapath #(
    .ADDR_W(ADDR_W), .FRAME_WORDS(FRAME_WORDS), .IDX_W(IDX_W),
    .CH_W(CH_W), .OUT_W(OUT_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .maskBlankN(maskBlankN),
    .blueOut(blueOut), .greenOut(greenOut), .redOut(redOut)
  );

endmodule

// File: tb/palette_raster_fetch_tb.sv
`timescale 1ns/1ps
module palette_raster_fetch_tb;

  localparam int FRAMEW = 600;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsIn = 1'b1, vsIn = 1'b1, blankNIn = 1'b0;
  logic hsOut, vsOut, blankNOut;
  logic [9:0] blueOut, greenOut, redOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  palette_raster_fetch #(.FRAME_WORDS(FRAMEW)) u_dut (
    .clk(clk), .rstN(rstN), .hsIn(hsIn), .vsIn(vsIn), .blankNIn(blankNIn),
    .hsOut(hsOut), .vsOut(vsOut), .blankNOut(blankNOut),
    .blueOut(blueOut), .greenOut(greenOut), .redOut(redOut)
  );

  // reference model state
  int        mAddr;
  logic [23:0] m1Word;
  logic      m1Hs, m1Vs, m1Bn;
  logic [9:0] eB, eG, eR;
  logic      eHs, eVs, eBn;

  function automatic int imgRef(int a);
    if (a >= FRAMEW) return 0;
    return ((a % 256) + ((a / 256) % 256)) % 256;
  endfunction

  function automatic logic [23:0] palRef(int i);
    logic [7:0] b, g, r;
    b = 8'(i);
    g = 8'(i) ^ 8'h5A;
    r = 8'(255 - i);
    return {b, g, r};
  endfunction

  function automatic logic [9:0] widen(logic [7:0] c);
    return 10'(c) * 10'd4 + 10'(c / 64);
  endfunction

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(string phase);
    string ctag;
    check("R7", {9'd0, hsOut}, {9'd0, eHs}, {"hsOut ", phase});
    check("R7", {9'd0, vsOut}, {9'd0, eVs}, {"vsOut ", phase});
    check("R7", {9'd0, blankNOut}, {9'd0, eBn}, {"blankNOut ", phase});
    ctag = eBn ? "R5" : "R8";
    check(ctag, blueOut, eB, {"blue ", phase});
    check(ctag, greenOut, eG, {"green ", phase});
    check(ctag, redOut, eR, {"red ", phase});
  endtask

  task automatic tick(logic hs, logic vs, logic bn, string phase);
    hsIn = hs; vsIn = vs; blankNIn = bn;
    @(posedge clk);
    // output stage from stage 1
    eHs = m1Hs; eVs = m1Vs; eBn = m1Bn;
    if (m1Bn) begin
      eB = widen(m1Word[23:16]); eG = widen(m1Word[15:8]); eR = widen(m1Word[7:0]);
    end else begin
      eB = '0; eG = '0; eR = '0;
    end
    // stage 1 from current address and inputs
    m1Word = palRef(imgRef(mAddr));
    m1Hs = hs; m1Vs = vs; m1Bn = bn;
    // address update (clear beats step), 19-bit
    if (!hs && !vs)  mAddr = 0;
    else if (bn)     mAddr = (mAddr + 1) % (1 << 19);
    #1;
    compareAll(phase);
  endtask

  initial begin
    logic [15:0] lfsr;
    mAddr = 0; m1Word = '0; m1Hs = 1; m1Vs = 1; m1Bn = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    eHs = 1; eVs = 1; eBn = 0; eB = 0; eG = 0; eR = 0;
    compareAll("R1 reset");
    rstN = 1'b1;

    // R4/R6: sweep past the end of the shortened image store
    for (int k = 0; k < FRAMEW + 120; k++) tick(1, 1, 1, "R4 R6 sweep");
    // blanked stretch: address holds
    for (int k = 0; k < 20; k++) tick(1, 1, 0, "R3 hold");
    for (int k = 0; k < 10; k++) tick(1, 1, 1, "R3 resume");
    // R2: clear coinciding with active video
    tick(0, 0, 1, "R2 clear with step");
    for (int k = 0; k < 6; k++) tick(1, 1, 1, "R2 after clear");
    tick(0, 1, 1, "R2 hs low alone");
    tick(1, 0, 1, "R2 vs low alone");
    for (int k = 0; k < 4; k++) tick(1, 1, 1, "R2 no clear");
    tick(0, 0, 0, "R2 clear blanked");
    for (int k = 0; k < 4; k++) tick(1, 1, 1, "R2 after blanked clear");

    // pseudo-random timing inputs
    lfsr = 16'hACE1;
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(lfsr[0] | lfsr[5] | lfsr[9], lfsr[1] | lfsr[3] | lfsr[7],
           lfsr[2] | lfsr[4], "R3 R7 R8 random");
    end
    // flush
    for (int k = 0; k < 3; k++) tick(1, 1, 0, "R8 flush");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(60000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule